// File: doc/BRIEF.md
# Indexed Configuration Access Router

This block sits at the host side of a root complex and steers every configuration-space access that the host issues. A small host address map sets the target of each access. A page of directly decoded local registers holds the root port's own configuration words. A single index register holds a target bus, device and function. A data aperture is then read and written on behalf of whatever target the index register holds.

An aperture access whose stored target is bus 0, device 0 is served from the local register file, because bus 0 is the root port itself. An aperture access to any other legal target becomes exactly one request on a downstream request port. That request carries the stored target, the register offset, the byte enables and the write data, and the answer is handed back to the host with a valid strobe. The first two buses can hold only device 0, so an aperture access to a higher device number on bus 0 or bus 1 is refused, and so is any host address outside the map. A refused read returns all ones, a refused write is discarded, and an error strobe is raised.

One field of the local file is the class code. When software programs it to the bridge class, a status output reports that the root port presents itself as a PCI-to-PCI bridge.

Top module: `cfg_access_router`

## Requirements
- R1: After synchronous reset, host_ready is 1, host_rvalid, host_err, dn_valid and bridge_mode are 0, the index register reads back 0 and every local register word reads 0 (with the default reset class of 0).
- R2: Host addresses 0x0000 to 0x0FFF reach the local register file directly, at word (addr[11:2]). A write updates only the bytes whose host_be bit is set. Every accepted local access gives host_rvalid one cycle later; a read returns the word, a write returns 0. Words at or beyond the file depth read as 0, and writes to them are dropped.
- R3: A write to host address 0x9000 loads the index register from host_wdata: bus from bits 27:20, device from bits 19:15, function from bits 14:12. Byte enables are ignored. A read of 0x9000 returns those fields in the same positions, with every other bit 0.
- R4: The index register keeps its value until 0x9000 is written again. Aperture accesses and refused accesses leave it unchanged.
- R5: An aperture access (host addresses 0x8000 to 0x8FFF) with a stored bus of 2 or more, or bus 1 with device 0, raises dn_valid for exactly one cycle, one cycle after acceptance. The request carries the stored bus, device and function, the offset addr[11:0], host_be, host_wdata and the write flag.
- R6: host_ready is low from the cycle after a downstream request is accepted until the response returns. One cycle after dn_rsp_valid, host_rvalid pulses, with dn_rsp_data for a read or 0 for a write, and host_ready returns high.
- R7: An aperture access with a stored target of bus 0, device 0 is served by the local register file at offset addr[11:0], exactly as in R2, and issues no downstream request.
- R8: An aperture access with a stored bus of 0 or 1 and a device above 0 is refused. A refused read returns 0xFFFFFFFF and a refused write returns 0. The write is dropped, host_err pulses together with host_rvalid one cycle after acceptance, and no downstream request is issued.
- R9: A host address that is neither a local address, an aperture address nor the index address 0x9000 is refused in the same way as R8.
- R10: bridge_mode is 1 exactly when bits 31:8 of local word 2 (offset 0x008) hold 0x060400.
- R11: Bus 1 with device 0 is a legal downstream target, and its function number passes through unchanged.
- R12: A host access presented while host_ready is low is ignored and has no effect on any register or output. A dn_rsp_valid that arrives while no downstream request is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host access request, taken when host_ready is high |
| host_write | input | 1 | 1 for write, 0 for read |
| host_addr | input | 16 | Host byte address within the router map |
| host_be | input | 4 | Byte enables of the access |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | Router can take a new access |
| host_rvalid | output | 1 | Completion strobe for an accepted access |
| host_rdata | output | 32 | Read data that goes with host_rvalid |
| host_err | output | 1 | Access refused, pulses with host_rvalid |
| dn_valid | output | 1 | Downstream request strobe |
| dn_write | output | 1 | Downstream request is a write |
| dn_bus | output | 8 | Target bus number |
| dn_dev | output | 5 | Target device number |
| dn_fn | output | 3 | Target function number |
| dn_off | output | 12 | Register byte offset within the target |
| dn_be | output | 4 | Downstream byte enables |
| dn_wdata | output | 32 | Downstream write data |
| dn_rsp_valid | input | 1 | Downstream response strobe |
| dn_rsp_data | input | 32 | Downstream response data |
| bridge_mode | output | 1 | Root port currently presents the bridge class |

## Verification
Local, index and refused accesses complete one clock after the edge that accepts them, so the bench drives each access on a falling edge and reads host_rvalid, host_rdata and host_err on the next falling edge. A downstream request appears on dn_valid at that same falling edge and must be gone one edge later. Its completion appears one edge after the edge that samples dn_rsp_valid, so the bench holds the response for one cycle and checks on the falling edge that follows. Both the R12 stimuli, a busy-time access and a stray response, are followed at once by a falling-edge check that host_rvalid stayed low and by a later read of the register that the access would have written.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;
    localparam int ADDR_W = 16;
    localparam int OFF_W  = 12;
    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FN_W   = 3;

    localparam logic [3:0]        LOCAL_PAGE   = 4'h0;
    localparam logic [3:0]        WINDOW_PAGE  = 4'h8;
    localparam logic [ADDR_W-1:0] INDEX_ADDR   = 16'h9000;
    localparam logic [23:0]       BRIDGE_CLASS = 24'h060400;

    typedef struct packed {
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  fn;
    } tgt_t;

    typedef enum logic [1:0] {
        RT_LOCAL  = 2'd0,
        RT_INDEX  = 2'd1,
        RT_DOWN   = 2'd2,
        RT_REJECT = 2'd3
    } route_e;

    function automatic tgt_t unpack_index(input logic [DATA_W-1:0] w);
        tgt_t t;
        t.bus = w[27:20];
        t.dev = w[19:15];
        t.fn  = w[14:12];
        return t;
    endfunction

    function automatic logic [DATA_W-1:0] pack_index(input tgt_t t);
        return {4'h0, t.bus, t.dev, t.fn, 12'h000};
    endfunction

    // buses 0 and 1 only carry device 0
    function automatic logic tgt_allowed(input tgt_t t);
        return !((t.bus < BUS_W'(2)) && (t.dev != '0));
    endfunction

endpackage

// File: rtl/cfgr_decode.sv
module cfgr_decode
    import cfgr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  tgt_t              tgt,
    output route_e            route
);
    always_comb begin
        if (addr[ADDR_W-1:OFF_W] == LOCAL_PAGE) begin
            route = RT_LOCAL;
        end else if (addr[ADDR_W-1:OFF_W] == WINDOW_PAGE) begin
            if (!tgt_allowed(tgt))
                route = RT_REJECT;
            else if (tgt.bus == '0)
                route = RT_LOCAL;
            else
                route = RT_DOWN;
        end else if (addr[ADDR_W-1:2] == INDEX_ADDR[ADDR_W-1:2]) begin
            route = RT_INDEX;
        end else begin
            route = RT_REJECT;
        end
    end
endmodule

// File: rtl/cfgr_index_reg.sv
module cfgr_index_reg
    import cfgr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  tgt_t wr_tgt,
    output tgt_t tgt
);
    always_ff @(posedge clk) begin
        if (rst)
            tgt <= '0;
        else if (wr_en)
            tgt <= wr_tgt;
    end

    assert_index_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(tgt));
endmodule

// File: rtl/cfgr_local_regs.sv
module cfgr_local_regs
    import cfgr_pkg::*;
#(
    parameter int          DEPTH       = 16,
    parameter int          CLASS_WORD  = 2,
    parameter logic [23:0] RESET_CLASS = 24'h000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFF_W-3:0]  word_off,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [23:0]       class_code
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] regs [DEPTH];
    logic [IDX_W-1:0]  widx;
    logic              in_range;

    assign in_range = (32'(word_off) < DEPTH);
    assign widx     = word_off[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < DEPTH; w++)
                regs[w] <= (w == CLASS_WORD) ? {RESET_CLASS, 8'h00} : '0;
        end else if (wr_en && in_range) begin
            for (int b = 0; b < BE_W; b++)
                if (be[b])
                    regs[widx][8*b +: 8] <= wdata[8*b +: 8];
        end
    end

    assign rdata      = in_range ? regs[widx] : '0;
    assign class_code = regs[CLASS_WORD][DATA_W-1:8];

    assert_range_drop_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !in_range) |=> $stable(class_code));
endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
    import cfgr_pkg::*;
#(
    parameter int          LOCAL_DEPTH = 16,
    parameter logic [23:0] RESET_CLASS = 24'h000000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_valid,
    input  logic        host_write,
    input  logic [15:0] host_addr,
    input  logic [3:0]  host_be,
    input  logic [31:0] host_wdata,
    output logic        host_ready,
    output logic        host_rvalid,
    output logic [31:0] host_rdata,
    output logic        host_err,
    output logic        dn_valid,
    output logic        dn_write,
    output logic [7:0]  dn_bus,
    output logic [4:0]  dn_dev,
    output logic [2:0]  dn_fn,
    output logic [11:0] dn_off,
    output logic [3:0]  dn_be,
    output logic [31:0] dn_wdata,
    input  logic        dn_rsp_valid,
    input  logic [31:0] dn_rsp_data,
    output logic        bridge_mode
);
    localparam int CLASS_WORD = 2;

    tgt_t              cur_tgt;
    route_e            route;
    logic              accept;
    logic              pending;
    logic              pend_write;
    logic [DATA_W-1:0] local_rdata;
    logic [23:0]       class_code;
    logic              unused_lsb;

    assign unused_lsb = ^host_addr[1:0];
    assign accept     = host_valid && !pending;
    assign host_ready = !pending;

    cfgr_decode u_decode (
        .addr  (host_addr),
        .tgt   (cur_tgt),
        .route (route)
    );

    cfgr_index_reg u_index (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (accept && host_write && (route == RT_INDEX)),
        .wr_tgt (unpack_index(host_wdata)),
        .tgt    (cur_tgt)
    );

    cfgr_local_regs #(
        .DEPTH       (LOCAL_DEPTH),
        .CLASS_WORD  (CLASS_WORD),
        .RESET_CLASS (RESET_CLASS)
    ) u_local (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (accept && host_write && (route == RT_LOCAL)),
        .word_off   (host_addr[OFF_W-1:2]),
        .be         (host_be),
        .wdata      (host_wdata),
        .rdata      (local_rdata),
        .class_code (class_code)
    );

    assign bridge_mode = (class_code == BRIDGE_CLASS);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending     <= 1'b0;
            pend_write  <= 1'b0;
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
            host_err    <= 1'b0;
            dn_valid    <= 1'b0;
            dn_write    <= 1'b0;
            dn_bus      <= '0;
            dn_dev      <= '0;
            dn_fn       <= '0;
            dn_off      <= '0;
            dn_be       <= '0;
            dn_wdata    <= '0;
        end else begin
            host_rvalid <= 1'b0;
            host_err    <= 1'b0;
            dn_valid    <= 1'b0;
            if (accept) begin
                unique case (route)
                    RT_LOCAL: begin
                        host_rvalid <= 1'b1;
                        host_rdata  <= host_write ? '0 : local_rdata;
                    end
                    RT_INDEX: begin
                        host_rvalid <= 1'b1;
                        host_rdata  <= host_write ? '0 : pack_index(cur_tgt);
                    end
                    RT_DOWN: begin
                        dn_valid   <= 1'b1;
                        dn_write   <= host_write;
                        dn_bus     <= cur_tgt.bus;
                        dn_dev     <= cur_tgt.dev;
                        dn_fn      <= cur_tgt.fn;
                        dn_off     <= host_addr[OFF_W-1:0];
                        dn_be      <= host_be;
                        dn_wdata   <= host_wdata;
                        pending    <= 1'b1;
                        pend_write <= host_write;
                    end
                    default: begin
                        host_rvalid <= 1'b1;
                        host_err    <= 1'b1;
                        host_rdata  <= host_write ? '0 : '1;
                    end
                endcase
            end else if (pending && dn_rsp_valid) begin
                host_rvalid <= 1'b1;
                host_rdata  <= pend_write ? '0 : dn_rsp_data;
                pending     <= 1'b0;
            end
        end
    end

    assert_err_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        host_err |-> host_rvalid);

    assert_dn_target_legal_R8: assert property (@(posedge clk) disable iff (rst)
        dn_valid |-> (dn_bus != 8'd0) && !((dn_bus == 8'd1) && (dn_dev != 5'd0)));

    assert_dn_single_R5: assert property (@(posedge clk) disable iff (rst)
        dn_valid |=> !dn_valid);

    assert_busy_after_issue_R6: assert property (@(posedge clk) disable iff (rst)
        dn_valid |-> (!host_ready && !host_rvalid));

    assert_ignore_while_busy_R12: assert property (@(posedge clk) disable iff (rst)
        (!host_ready && !dn_rsp_valid) |=> (!host_rvalid && !dn_valid));
endmodule

// File: tb/sim_cfg_access_router.sv
module sim_cfg_access_router;

    typedef struct packed {
        logic [3:0]  req;
        logic        wr;
        logic [15:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic        exp_err;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{4'd2,  1'b1, 16'h0008, 4'hF, 32'h06040000, 32'h00000000, 1'b0}, // R2 class write
        '{4'd2,  1'b0, 16'h0008, 4'hF, 32'h0,        32'h06040000, 1'b0}, // R2
        '{4'd2,  1'b1, 16'h0004, 4'h5, 32'hAABBCCDD, 32'h00000000, 1'b0}, // R2 partial bytes
        '{4'd2,  1'b0, 16'h0004, 4'hF, 32'h0,        32'h00BB00DD, 1'b0}, // R2
        '{4'd2,  1'b0, 16'h0100, 4'hF, 32'h0,        32'h00000000, 1'b0}, // R2 beyond depth
        '{4'd3,  1'b1, 16'h9000, 4'h0, 32'h00108000, 32'h00000000, 1'b0}, // R3 bus1 dev1
        '{4'd3,  1'b0, 16'h9000, 4'hF, 32'h0,        32'h00108000, 1'b0}, // R3
        '{4'd8,  1'b0, 16'h8010, 4'hF, 32'h0,        32'hFFFFFFFF, 1'b1}, // R8 bus1 dev1 read
        '{4'd8,  1'b1, 16'h8010, 4'hF, 32'h12345678, 32'h00000000, 1'b1}, // R8 write dropped
        '{4'd3,  1'b1, 16'h9000, 4'hF, 32'hF0008000, 32'h00000000, 1'b0}, // R3 bus0 dev1
        '{4'd3,  1'b0, 16'h9000, 4'hF, 32'h0,        32'h00008000, 1'b0}, // R3 upper bits clear
        '{4'd8,  1'b0, 16'h8000, 4'hF, 32'h0,        32'hFFFFFFFF, 1'b1}, // R8 bus0 dev1
        '{4'd3,  1'b1, 16'h9000, 4'hF, 32'h00000000, 32'h00000000, 1'b0}, // R3 bus0 dev0
        '{4'd7,  1'b0, 16'h8008, 4'hF, 32'h0,        32'h06040000, 1'b0}, // R7 aperture to local
        '{4'd7,  1'b1, 16'h8004, 4'hF, 32'h11223344, 32'h00000000, 1'b0}, // R7
        '{4'd7,  1'b0, 16'h0004, 4'hF, 32'h0,        32'h11223344, 1'b0}, // R7
        '{4'd9,  1'b0, 16'h4000, 4'hF, 32'h0,        32'hFFFFFFFF, 1'b1}, // R9 unmapped read
        '{4'd9,  1'b1, 16'h9004, 4'hF, 32'h00500000, 32'h00000000, 1'b1}, // R9 unmapped write
        '{4'd4,  1'b0, 16'h9000, 4'hF, 32'h0,        32'h00000000, 1'b0}  // R4 index unchanged
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [15:0] host_addr = '0;
    logic [3:0]  host_be = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ready, host_rvalid, host_err;
    logic [31:0] host_rdata;
    logic        dn_valid, dn_write;
    logic [7:0]  dn_bus;
    logic [4:0]  dn_dev;
    logic [2:0]  dn_fn;
    logic [11:0] dn_off;
    logic [3:0]  dn_be;
    logic [31:0] dn_wdata;
    logic        dn_rsp_valid = 1'b0;
    logic [31:0] dn_rsp_data = '0;
    logic        bridge_mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cfg_access_router u0 (
        .clk(clk), .rst(rst),
        .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
        .host_be(host_be), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata), .host_err(host_err),
        .dn_valid(dn_valid), .dn_write(dn_write), .dn_bus(dn_bus), .dn_dev(dn_dev),
        .dn_fn(dn_fn), .dn_off(dn_off), .dn_be(dn_be), .dn_wdata(dn_wdata),
        .dn_rsp_valid(dn_rsp_valid), .dn_rsp_data(dn_rsp_data),
        .bridge_mode(bridge_mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // drive on a falling edge, return on the falling edge after acceptance
    task automatic host_op(input logic wr, input logic [15:0] a, input logic [3:0] be,
                           input logic [31:0] wd);
        @(negedge clk);
        host_valid = 1'b1; host_write = wr; host_addr = a; host_be = be; host_wdata = wd;
        @(negedge clk);
        host_valid = 1'b0;
    endtask

    task automatic respond(input logic [31:0] d);
        @(negedge clk);
        dn_rsp_valid = 1'b1; dn_rsp_data = d;
        @(negedge clk);
        dn_rsp_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 50000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", 32'(host_ready), 32'd1);
        check("R1 rvalid", 32'(host_rvalid), 32'd0);
        check("R1 err", 32'(host_err), 32'd0);
        check("R1 dn_valid", 32'(dn_valid), 32'd0);
        check("R1 bridge", 32'(bridge_mode), 32'd0);
        host_op(1'b0, 16'h9000, 4'hF, 32'h0);
        check("R1 index", host_rdata, 32'h0);
        host_op(1'b0, 16'h0008, 4'hF, 32'h0);
        check("R1 class word", host_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            host_op(VECS[i].wr, VECS[i].addr, VECS[i].be, VECS[i].wdata);
            check({tag, " rvalid"}, 32'(host_rvalid), 32'd1);
            check({tag, " rdata"}, host_rdata, VECS[i].exp);
            check({tag, " err"}, 32'(host_err), 32'(VECS[i].exp_err));
            check({tag, " no dn"}, 32'(dn_valid), 32'd0);
        end

        // R10 bridge class present, then disturbed
        check("R10 bridge on", 32'(bridge_mode), 32'd1);
        host_op(1'b1, 16'h0008, 4'b0010, 32'h00000500);
        check("R10 bridge off", 32'(bridge_mode), 32'd0);

        // R5 downstream read to bus 5 dev 3 fn 2
        host_op(1'b1, 16'h9000, 4'hF, 32'h0051A000);
        host_op(1'b0, 16'h8044, 4'hF, 32'h0);
        check("R5 dn_valid", 32'(dn_valid), 32'd1);
        check("R5 dn_write", 32'(dn_write), 32'd0);
        check("R5 bus", 32'(dn_bus), 32'd5);
        check("R5 dev", 32'(dn_dev), 32'd3);
        check("R5 fn", 32'(dn_fn), 32'd2);
        check("R5 off", 32'(dn_off), 32'h044);
        check("R5 be", 32'(dn_be), 32'hF);
        check("R6 busy", 32'(host_ready), 32'd0);
        check("R6 no early rvalid", 32'(host_rvalid), 32'd0);
        @(negedge clk);
        check("R5 single pulse", 32'(dn_valid), 32'd0);
        // R12 access while busy
        host_op(1'b1, 16'h0004, 4'hF, 32'hDEADBEEF);
        check("R12 busy rvalid", 32'(host_rvalid), 32'd0);
        check("R12 busy dn", 32'(dn_valid), 32'd0);
        respond(32'hCAFEF00D);
        check("R6 rvalid", 32'(host_rvalid), 32'd1);
        check("R6 rdata", host_rdata, 32'hCAFEF00D);
        check("R6 ready", 32'(host_ready), 32'd1);
        host_op(1'b0, 16'h0004, 4'hF, 32'h0);
        check("R12 busy write dropped", host_rdata, 32'h11223344);
        // R12 stray response
        respond(32'h12345678);
        check("R12 stray rsp", 32'(host_rvalid), 32'd0);

        // R11 bus 1 dev 0 fn 7 downstream write
        host_op(1'b1, 16'h9000, 4'hF, 32'h00107000);
        host_op(1'b1, 16'h8FFC, 4'b0011, 32'h0000BEEF);
        check("R11 dn_valid", 32'(dn_valid), 32'd1);
        check("R11 dn_write", 32'(dn_write), 32'd1);
        check("R11 bus", 32'(dn_bus), 32'd1);
        check("R11 dev", 32'(dn_dev), 32'd0);
        check("R11 fn", 32'(dn_fn), 32'd7);
        check("R5 off max", 32'(dn_off), 32'hFFC);
        check("R5 be partial", 32'(dn_be), 32'h3);
        check("R5 wdata", dn_wdata, 32'h0000BEEF);
        repeat (2) @(negedge clk);
        check("R6 still busy", 32'(host_ready), 32'd0);
        respond(32'h55555555);
        check("R6 write rvalid", 32'(host_rvalid), 32'd1);
        check("R6 write rdata", host_rdata, 32'h0);
        host_op(1'b0, 16'h9000, 4'hF, 32'h0);
        check("R4 index after dn", host_rdata, 32'h00107000);

        finish_run();
    end
endmodule